// File: doc/BRIEF.md
# Grouped Prescaler Tick Generator

This block turns a single peripheral clock into one count-enable strobe per timer channel for a five-channel timer. Two 8-bit prescalers divide the clock. Each prescaler serves one group of channels. Every channel then has its own power-of-two divider, and that divider picks out the prescaler strobes that become the channel's tick. The channel counters elsewhere in the timer advance only in cycles where their tick is high.

Software sets the block up through two word registers on a simple write port. One register holds both prescaler values. The other holds a 4-bit divider select for each channel. A select code stands for the base-2 logarithm of the division ratio, less a fixed offset set by the parameter `DIV_BASE`. Ratios above the supported maximum stand for external clock sources, which this block does not serve, so those channels stay silent. There is no streaming data path. All pins are plain control signals, and a write is taken in every cycle where `cfg_wr` is high.

Top module: `timer_tick_gen`

## Requirements
- R1: While `rst_n` is low, `tick_o` is all zero. After reset, both prescaler values and all divider selects are zero.
- R2: A write to byte address 0x0 sets prescaler A from `cfg_wdata[7:0]` and prescaler B from `cfg_wdata[15:8]`. Channels 0 and 1 use prescaler A. Channels 2, 3 and 4 use prescaler B.
- R3: A prescaler value p emits one strobe every p+1 clock cycles.
- R4: A write to byte address 0x4 sets the divider select of channel n from `cfg_wdata[4n+3:4n]`. A select code s gives one tick per 2^(s+DIV_BASE) prescaler strobes, so a channel's tick period is (p+1)·2^(s+DIV_BASE) cycles. The default DIV_BASE is 1.
- R5: A select code whose ratio 2^(s+DIV_BASE) is larger than 16 gives no ticks on that channel.
- R6: A new prescaler value takes effect only after the running count reaches its current terminal value and wraps. The count in progress is not cut short.
- R7: Each tick lasts one clock cycle whenever the channel's period is longer than one cycle.
- R8: A write to any byte address other than 0x0 and 0x4 changes no setting.
- R9: A change to one prescaler does not change the tick period of channels in the other group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write enable, one write per high cycle |
| cfg_addr | input | 3 | Byte address of the register being written |
| cfg_wdata | input | 32 | Write data |
| tick_o | output | 5 | One count-enable strobe per channel |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge, so every register, and the prescaler terminal value in particular, starts from a known value. They also assume that the write inputs are driven away from the clock edge, so each write is taken exactly once. The bench holds reset for several cycles and changes the write pins only on falling edges. Each write lasts exactly one cycle. The bench waits for any running period check to finish before it writes again. The one exception is the deferred-load test, where a write is placed on purpose in a known prescaler phase.

// File: rtl/timer_tick_pkg.sv
package timer_tick_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_PRESCALE = 3'h0;
  localparam logic [ADDR_W-1:0] ADDR_DIVSEL   = 3'h4;
  localparam int unsigned NUM_PSC = 2;

  typedef enum logic { PSC_A = 1'b0, PSC_B = 1'b1 } psc_id_e;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [PSC_W-1:0] load_val,
  output logic             strobe,
  output logic [PSC_W-1:0] cnt_o,
  output logic [PSC_W-1:0] term_o
);
  logic [PSC_W-1:0] cnt_q, term_q, pend_q, pend_next;

  always_comb begin
    pend_next = load_en ? load_val : pend_q;
    strobe    = (cnt_q == term_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      term_q <= '0;
      pend_q <= '0;
    end else begin
      pend_q <= pend_next;
      if (strobe) begin
        cnt_q  <= '0;
        term_q <= pend_next;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign term_o = term_q;
endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned DIV_BASE = 1,
  parameter int unsigned MAX_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_stb,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned CW = (MAX_LOG2 < 1) ? 1 : MAX_LOG2;

  logic [CW-1:0] dcnt_q, mask;
  logic [31:0]   lg, full;
  logic          ratio_ok, tick_q;

  always_comb begin
    lg       = 32'(sel) + 32'(DIV_BASE);
    ratio_ok = (lg <= 32'(MAX_LOG2));
    full     = (32'd1 << lg) - 32'd1;
    mask     = ratio_ok ? full[CW-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dcnt_q <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= pre_stb && ratio_ok && ((dcnt_q & mask) == mask);
      if (pre_stb) dcnt_q <= dcnt_q + 1'b1;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/timer_tick_gen.sv
module timer_tick_gen
  import timer_tick_pkg::*;
#(
  parameter int unsigned NUM_CH   = 5,
  parameter int unsigned PSC_W    = 8,
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned DIV_BASE = 1,
  parameter int unsigned MAX_LOG2 = 4,
  parameter int unsigned GRP_A_CH = 2,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_wr,
  input  logic [timer_tick_pkg::ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0]          cfg_wdata,
  output logic [NUM_CH-1:0]          tick_o
);
  localparam int unsigned SEL_BITS = NUM_CH * SEL_W;

  logic                   wr_psc, wr_div;
  logic [SEL_BITS-1:0]    divsel_q;
  logic [NUM_PSC-1:0]     psc_stb;
  logic [PSC_W-1:0]       psc_cnt  [NUM_PSC];
  logic [PSC_W-1:0]       psc_term [NUM_PSC];

  assign wr_psc = cfg_wr && (cfg_addr == ADDR_PRESCALE);
  assign wr_div = cfg_wr && (cfg_addr == ADDR_DIVSEL);

  always_ff @(posedge clk) begin
    if (!rst_n)      divsel_q <= '0;
    else if (wr_div) divsel_q <= cfg_wdata[SEL_BITS-1:0];
  end

  for (genvar g = 0; g < NUM_PSC; g++) begin : g_psc
    tick_prescaler #(.PSC_W(PSC_W)) psc_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (wr_psc),
      .load_val (cfg_wdata[g*PSC_W +: PSC_W]),
      .strobe   (psc_stb[g]),
      .cnt_o    (psc_cnt[g]),
      .term_o   (psc_term[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam psc_id_e GRP = (c < GRP_A_CH) ? PSC_A : PSC_B;
    tick_divider #(
      .SEL_W    (SEL_W),
      .DIV_BASE (DIV_BASE),
      .MAX_LOG2 (MAX_LOG2)
    ) div_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .pre_stb (psc_stb[GRP]),
      .sel     (divsel_q[c*SEL_W +: SEL_W]),
      .tick    (tick_o[c])
    );
  end
endmodule

// File: rtl/timer_tick_chk.sv
module timer_tick_chk #(
  parameter int unsigned NUM_CH   = 5,
  parameter int unsigned PSC_W    = 8,
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned DIV_BASE = 1,
  parameter int unsigned MAX_LOG2 = 4,
  parameter int unsigned GRP_A_CH = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_CH-1:0]       tick,
  input logic [1:0]              stb,
  input logic [PSC_W-1:0]        cnt_a,
  input logic [PSC_W-1:0]        term_a,
  input logic [PSC_W-1:0]        cnt_b,
  input logic [PSC_W-1:0]        term_b,
  input logic [NUM_CH*SEL_W-1:0] divsel
);
  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_a <= term_a) && (cnt_b <= term_b));

  assert_term_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stb[0]) |-> $stable(term_a));

  assert_term_held_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stb[1]) |-> $stable(term_b));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    localparam int G = (c < GRP_A_CH) ? 0 : 1;
    logic too_slow;
    assign too_slow = (32'(divsel[c*SEL_W +: SEL_W]) + 32'(DIV_BASE)) > 32'(MAX_LOG2);

    assert_tick_after_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tick[c] |-> $past(stb[G]));

    assert_no_tick_slow_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(too_slow) |-> !tick[c]);
  end
endmodule

bind timer_tick_gen timer_tick_chk #(
  .NUM_CH(NUM_CH), .PSC_W(PSC_W), .SEL_W(SEL_W),
  .DIV_BASE(DIV_BASE), .MAX_LOG2(MAX_LOG2), .GRP_A_CH(GRP_A_CH)
) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick_o), .stb(psc_stb),
  .cnt_a(psc_cnt[0]), .term_a(psc_term[0]),
  .cnt_b(psc_cnt[1]), .term_b(psc_term[1]),
  .divsel(divsel_q)
);

// File: tb/timer_tick_gen_tb_top.sv
module timer_tick_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [4:0]  tick_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct { int ch; int per; string req; } item_t;
  item_t sbq[$];
  bit busy = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  timer_tick_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tick_o(tick_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_tick(input int ch, input string req, output int t);
    int n = 0;
    @(negedge clk);
    while (!tick_o[ch] && n < 10000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 10000) chk(1'b0, {req, " timeout"}, 0, 1);
    t = cyc;
  endtask

  task automatic run_item(input item_t it);
    int t1, t2, t3;
    bit seen;
    if (it.per == 0) begin
      repeat (3) @(negedge clk);
      seen = 1'b0;
      repeat (400) begin
        @(negedge clk);
        if (tick_o[it.ch]) seen = 1'b1;
      end
      chk(!seen, it.req, int'(seen), 0);
    end else begin
      wait_tick(it.ch, it.req, t1);
      wait_tick(it.ch, it.req, t2);
      wait_tick(it.ch, it.req, t3);
      chk((t3 - t2) == it.per, it.req, t3 - t2, it.per);
      @(negedge clk);
      if (it.per > 1) chk(!tick_o[it.ch], "R7", int'(tick_o[it.ch]), 0);
    end
  endtask

  task automatic push(input int ch, input int per, input string req);
    item_t it;
    it.ch = ch; it.per = per; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic drain();
    @(negedge clk);
    while (sbq.size() != 0 || busy) @(negedge clk);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      if (sbq.size() != 0) begin
        busy = 1'b1;
        it = sbq.pop_front();
        run_item(it);
        busy = 1'b0;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : driver
    int t0, t1, t2;
    repeat (4) begin
      @(negedge clk);
      chk(tick_o == 5'b0, "R1", int'(tick_o), 0);
    end
    rst_n = 1'b1;
    push(0, 2, "R1"); push(4, 2, "R1");
    drain();

    // R2 R3: A=4 for ch0/1, B=9 for ch2..4, select 0 -> ratio 2
    wr(3'h0, 32'h0000_0904);
    push(1, 10, "R2"); push(2, 20, "R3");
    drain();

    // R4 R5: sel ch0=2 ch1=0 ch2=1 ch3=3 ch4=4 (ratio 32)
    wr(3'h4, 32'h0004_3102);
    push(0, 40, "R4"); push(2, 40, "R4"); push(3, 160, "R4"); push(4, 0, "R5");
    drain();

    // R3 boundary p=255 on B, R9: group A untouched
    wr(3'h0, 32'h0000_FF04);
    push(3, 4096, "R3"); push(0, 40, "R9");
    drain();

    // R8: writes to other addresses change nothing
    wr(3'h2, 32'h0000_0000);
    wr(3'h6, 32'h0000_0000);
    push(2, 1024, "R8"); push(0, 40, "R8"); push(1, 10, "R8");
    drain();

    // R5: select 15 on ch4 also silent
    wr(3'h4, 32'h000F_3100);
    push(4, 0, "R5"); push(0, 10, "R4");
    drain();

    // R6: load A=9, settle, then change to 1 right at a ch0 tick
    wr(3'h0, 32'h0000_FF09);
    push(0, 20, "R3");
    drain();
    wait_tick(0, "R6", t0);
    cfg_wr = 1'b1; cfg_addr = 3'h0; cfg_wdata = 32'h0000_FF01;
    @(negedge clk);
    cfg_wr = 1'b0;
    wait_tick(0, "R6", t1);
    chk((t1 - t0) == 12, "R6", t1 - t0, 12);
    wait_tick(0, "R6", t2);
    chk((t2 - t1) == 4, "R6", t2 - t1, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule